// File: doc/BRIEF.md
# Horizontal Sync Timing Generator

The block produces the horizontal sync waveform for a 640-pixel-wide video mode. It runs on a system clock at four times the pixel rate, and an internal divide-by-4 enable marks the end of each pixel. Each line has four segments. The sync pulse comes first with the sync output low. The back porch follows, fixed at 120 pixels. The last segment joins the visible area and the front porch into one span. Two one-cycle strobes time the other video engines. `line_stb` marks the start of a line, the cycle in which sync falls. `vis_stb` marks the end of the back porch, where pixel shifting should begin.

Two span lengths are loaded through a small write port while the block is disabled: the sync-pulse length and the visible-plus-front-porch length, both counted in pixels. Once `en` is raised, the line pattern repeats with no further input. Lowering `en` returns the block to idle, with sync high and the counters held at the line start.

The controller is a four-state machine. IDLE goes to PULSE on the first edge with `en` high. PULSE goes to BACK after the pulse length. BACK goes to ACTIVE after 120 pixels. ACTIVE goes back to PULSE after the visible-plus-front-porch length. Every state returns to IDLE on an edge where `en` is low.

Top module: `hsync_gen`

## Requirements
- R1: After reset, `hs_n` is 1 and `line_stb` and `vis_stb` are 0.
- R2: One pixel lasts 4 clock cycles. `hs_n` stays low for exactly 4*P cycles from the cycle in which `line_stb` is high, where P is the pulse length in pixels.
- R3: Consecutive `line_stb` pulses are exactly 4*(P+120+A) cycles apart, where A is the visible-plus-front-porch length. With the defaults this is 3360 cycles.
- R4: `line_stb` is high for one cycle, in the same cycle that `hs_n` goes low. The first one appears in the cycle after the first clock edge that samples `en` high.
- R5: `vis_stb` is high for one cycle, 4*(P+120) cycles after `line_stb`.
- R6: A write with `cfg_wr`=1 loads `cfg_data` as P when `cfg_sel`=0 and as A when `cfg_sel`=1. After reset P=64 and A=656.
- R7: One cycle after an edge that samples `en` low, `hs_n` is 1 and no strobe is issued until `en` is high again. A new enable restarts the line from its start.
- R8: A configuration write while `en` is 1 is ignored.
- R9: A configuration write of value 0 is ignored, and the length keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 4x pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects pulse length, 1 selects visible-plus-front-porch length |
| cfg_data | input | 10 | Length in pixels |
| hs_n | output | 1 | Horizontal sync, active low |
| line_stb | output | 1 | Start-of-line strobe |
| vis_stb | output | 1 | Start-of-visible-line strobe |

## Verification
Any fault in the pixel phase counter or the segment counter shifts a sync edge or a strobe by a whole number of cycles. The scoreboard sees the shift at the first event of the first affected line, so at most one line period after the fault. A wrong state transition either drops a `vis_stb` or adds one, or it moves the next `line_stb`, and the monitor reports this at the following event. Bad configuration handling shows up as a wrong pulse width or line period on the first line after enable.

// File: rtl/hsync_pkg.sv
package hsync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_BACK,
        ST_ACTIVE
    } hs_state_t;

    localparam int BACK_PIX = 120;
endpackage

// File: rtl/hsync_cfg.sv
module hsync_cfg #(
    parameter int CNT_W     = 10,
    parameter int DEF_PULSE = 64,
    parameter int DEF_ACT   = 656
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_data,
    output logic [CNT_W-1:0] pulse_len,
    output logic [CNT_W-1:0] act_len
);
    logic accept;
    assign accept = cfg_wr && !en && (cfg_data != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_len <= CNT_W'(DEF_PULSE);
            act_len   <= CNT_W'(DEF_ACT);
        end else if (accept) begin
            if (cfg_sel) act_len <= cfg_data;
            else         pulse_len <= cfg_data;
        end
    end

    // R8
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cfg_wr) |=> ($stable(pulse_len) && $stable(act_len)));

    // R9
    cfg_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_len != '0) && (act_len != '0));
endmodule

// File: rtl/hsync_pixdiv.sv
module hsync_pixdiv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || !run)                 ph_q <= '0;
        else if (ph_q == PH_W'(DIV - 1)) ph_q <= '0;
        else                             ph_q <= ph_q + 1'b1;
    end

    assign tick = run && (ph_q == PH_W'(DIV - 1));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/hsync_fsm.sv
module hsync_fsm
    import hsync_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] pulse_len,
    input  logic [CNT_W-1:0] act_len,
    output logic             run,
    output logic             hs_n,
    output logic             line_stb,
    output logic             vis_stb
);
    hs_state_t       state_q;
    logic [CNT_W-1:0] pc_q;
    logic [CNT_W-1:0] seg_len;
    logic             seg_end;

    always_comb begin
        unique case (state_q)
            ST_PULSE:  seg_len = pulse_len;
            ST_BACK:   seg_len = CNT_W'(BACK_PIX);
            ST_ACTIVE: seg_len = act_len;
            default:   seg_len = CNT_W'(1);
        endcase
    end

    assign seg_end = tick && (pc_q == seg_len - 1'b1);
    assign run     = en && (state_q != ST_IDLE);

    // state register and pixel counter
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_q <= ST_PULSE;
                    pc_q    <= '0;
                end
                ST_PULSE, ST_BACK, ST_ACTIVE: begin
                    if (seg_end) begin
                        pc_q <= '0;
                        unique case (state_q)
                            ST_PULSE: state_q <= ST_BACK;
                            ST_BACK:  state_q <= ST_ACTIVE;
                            default:  state_q <= ST_PULSE;
                        endcase
                    end else if (tick) begin
                        pc_q <= pc_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_n     <= 1'b1;
            line_stb <= 1'b0;
            vis_stb  <= 1'b0;
        end else begin
            line_stb <= 1'b0;
            vis_stb  <= 1'b0;
            if (!en) begin
                hs_n <= 1'b1;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        hs_n     <= 1'b0;
                        line_stb <= 1'b1;
                    end
                    ST_PULSE: if (seg_end) hs_n <= 1'b1;
                    ST_BACK:  if (seg_end) vis_stb <= 1'b1;
                    ST_ACTIVE: if (seg_end) begin
                        hs_n     <= 1'b0;
                        line_stb <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R4
    line_single_chk: assert property (@(posedge clk) disable iff (rst)
        line_stb |=> !line_stb);

    // R4
    line_low_chk: assert property (@(posedge clk) disable iff (rst)
        line_stb |-> !hs_n);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_stb && vis_stb));

    // R7
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hs_n && !line_stb && !vis_stb));
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
    parameter int CNT_W     = 10,
    parameter int PIX_DIV   = 4,
    parameter int DEF_PULSE = 64,
    parameter int DEF_ACT   = 656
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CNT_W-1:0] cfg_data,
    output logic             hs_n,
    output logic             line_stb,
    output logic             vis_stb
);
    logic [CNT_W-1:0] pulse_len;
    logic [CNT_W-1:0] act_len;
    logic             run;
    logic             tick;

    hsync_cfg #(
        .CNT_W(CNT_W), .DEF_PULSE(DEF_PULSE), .DEF_ACT(DEF_ACT)
    ) u_cfg (
        .clk(clk), .rst(rst), .en(en),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .pulse_len(pulse_len), .act_len(act_len)
    );

    hsync_pixdiv #(.DIV(PIX_DIV)) u_div (
        .clk(clk), .rst(rst), .run(run), .tick(tick)
    );

    hsync_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .en(en), .tick(tick),
        .pulse_len(pulse_len), .act_len(act_len),
        .run(run), .hs_n(hs_n), .line_stb(line_stb), .vis_stb(vis_stb)
    );
endmodule

// File: tb/sim_hsync_gen.sv
module sim_hsync_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [9:0] cfg_data = '0;
    logic       hs_n, line_stb, vis_stb;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic prev_hs = 1'b1;

    // event kinds: 0 = line strobe, 1 = sync rise, 2 = visible strobe
    int    exp_kind[$];
    int    exp_cyc[$];
    string exp_req[$];

    hsync_gen u0 (
        .clk(clk), .rst(rst), .en(en),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .hs_n(hs_n), .line_stb(line_stb), .vis_stb(vis_stb)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic take(input int kind);
        if (exp_kind.size() == 0) begin
            check(1'b0, "R7 unexpected event", kind, -1);
        end else begin
            int    k = exp_kind.pop_front();
            int    c = exp_cyc.pop_front();
            string r = exp_req.pop_front();
            check(k == kind, r, kind, k);
            check(c == cyc, r, cyc, c);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (line_stb) begin
                take(0);
                check(hs_n == 1'b0, "R4 sync low with line strobe", hs_n, 0);
            end
            if (hs_n && !prev_hs) take(1);
            if (vis_stb) take(2);
        end
        prev_hs <= hs_n;
    end

    task automatic cfg_write(input bit sel, input int val);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_sel  = sel;
        cfg_data = 10'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // driver: enable, push expected events for n lines, disable before line n+1
    task automatic run_lines(input int p, input int a, input int n, input string tag,
                             input bit poke);
        int t0, len;
        @(negedge clk);
        en = 1'b1;
        t0 = cyc + 1;
        len = 4 * (p + 120 + a);
        for (int i = 0; i < n; i++) begin
            exp_kind.push_back(0); exp_cyc.push_back(t0 + i * len);
            exp_req.push_back({"R3 R4 ", tag});
            exp_kind.push_back(1); exp_cyc.push_back(t0 + i * len + 4 * p);
            exp_req.push_back({"R2 ", tag});
            exp_kind.push_back(2); exp_cyc.push_back(t0 + i * len + 4 * (p + 120));
            exp_req.push_back({"R5 ", tag});
        end
        if (poke) begin
            repeat (5) @(negedge clk);
            cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 10'd5;
            @(negedge clk);
            cfg_sel = 1'b1; cfg_data = 10'd7;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        while (cyc < t0 + n * len - 2) @(negedge clk);
        en = 1'b0;
        repeat (40) @(negedge clk);
        check(hs_n == 1'b1, "R7 idle sync high", hs_n, 1);
        check(exp_kind.size() == 0, {"R7 missing events ", tag}, exp_kind.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(hs_n == 1'b1, "R1 reset sync", hs_n, 1);
        check(line_stb == 1'b0, "R1 reset line strobe", line_stb, 0);
        check(vis_stb == 1'b0, "R1 reset visible strobe", vis_stb, 0);

        // R6 defaults 64/656
        run_lines(64, 656, 3, "R6 defaults", 1'b0);

        // R7 nothing while disabled (monitor flags any event)
        repeat (600) @(negedge clk);
        check(line_stb == 1'b0 && vis_stb == 1'b0, "R7 no strobes idle", line_stb, 0);

        // R6 new lengths, R8 writes during run ignored
        cfg_write(1'b0, 10);
        cfg_write(1'b1, 30);
        run_lines(10, 30, 4, "R6 R8 p10 a30", 1'b1);

        // R9 zero write ignored, minimum lengths
        cfg_write(1'b0, 1);
        cfg_write(1'b1, 1);
        cfg_write(1'b0, 0);
        cfg_write(1'b1, 0);
        run_lines(1, 1, 3, "R9 p1 a1", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule